// File: doc/BRIEF.md
# Clock Lock Confirmation Poller

This block decides whether a reconfigured serial lane has a recovered clock that is locked to its PLL. A single start pulse launches a check on one lane of an even/odd lane pair. The block then waits a fixed poll interval, samples that lane's ready bit, and repeats. Lock is declared only after an unbroken run of good samples. If the poll budget runs out first, the block reports a timeout.

The poll interval is set in clock cycles by a parameter. A real system uses a value near 10 ms of system clock, and simulation uses a few cycles. The ready bits of both lanes of the pair come straight in as a two-bit input. Each result is announced by a one-cycle done pulse. The ok or timeout flag stays up until the next accepted start.

Top module: `clk_ready_poller`

## Requirements
- R1: After reset, done, ok and timeout are low and the block is idle.
- R2: A start pulse while idle begins a check on the lane given by lane_odd in that cycle, and clears ok and timeout at the same clock edge.
- R3: The sampled bit is ready_pair[0] for the even lane (lane_odd=0) and ready_pair[1] for the odd lane (lane_odd=1). The other bit has no effect.
- R4: Samples are taken every POLL_CYCLES cycles. With the start accepted at edge 0, poll k (k=1,2,...) is taken at edge k*POLL_CYCLES, and any result of that poll appears at that same edge.
- R5: A low sample resets the consecutive-good count to zero. Success (ok=1) is reported at the poll where the count first reaches NEED_GOOD (default 3).
- R6: If MAX_POLLS (default 20) polls pass without success, timeout=1 is reported at the last poll. A success on that last poll takes priority over the timeout.
- R7: done is a one-cycle pulse, and exactly one of ok and timeout is high with it. ok and timeout hold their values until the next accepted start.
- R8: A start pulse while a check is in progress is ignored. It does not change the lane, the timing or the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lock check (one-cycle pulse) |
| lane_odd | input | 1 | Lane to check: 0 even, 1 odd |
| ready_pair | input | 2 | Raw clock-ready bits, [0] even lane, [1] odd lane |
| done | output | 1 | One-cycle pulse when a result is ready |
| ok | output | 1 | Lock confirmed; held until next start |
| timeout | output | 1 | Poll budget exhausted; held until next start |

## Verification
On every cycle the assertions check the following: done lasts one cycle, exactly one outcome flag accompanies it, and the flags rise only with done. They also check that the captured lane stays stable through a check and that no check runs longer than the full poll budget. The bench scenarios are the only way to show the rest. That covers the exact poll edge of each result, the reset of the run by a single bad sample, the priority of success on the final poll, the selection of the correct lane bit against a contrary neighbour, and the rejection of a start issued mid-check.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_POLL = 1'b1
  } poll_state_t;
endpackage

// File: rtl/poll_interval_timer.sv
module poll_interval_timer #(
  parameter int POLL_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);
  localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign hit = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || hit) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lane_bit_select.sv
module lane_bit_select (
  input  logic       odd,
  input  logic [1:0] pair,
  output logic       bit_o
);
  always_comb bit_o = odd ? pair[1] : pair[0];
endmodule

// File: rtl/lock_run_counter.sv
module lock_run_counter #(
  parameter int NEED_GOOD = 3,
  parameter int MAX_POLLS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample_en,
  input  logic sample_bit,
  output logic locked_now,
  output logic spent_now
);
  localparam int RW = $clog2(NEED_GOOD + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [RW-1:0] run_q, run_next;
  logic [PW-1:0] polls_q;

  always_comb begin
    run_next   = sample_bit ? run_q + 1'b1 : '0;
    locked_now = sample_en && sample_bit && (run_next == RW'(NEED_GOOD));
    spent_now  = sample_en && (polls_q == PW'(MAX_POLLS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q   <= '0;
      polls_q <= '0;
    end else if (sample_en) begin
      run_q   <= locked_now ? '0 : run_next;
      polls_q <= polls_q + 1'b1;
    end
  end
endmodule

// File: rtl/clk_ready_poller.sv
module clk_ready_poller #(
  parameter int POLL_CYCLES = 500000,
  parameter int NEED_GOOD   = 3,
  parameter int MAX_POLLS   = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       lane_odd,
  input  logic [1:0] ready_pair,
  output logic       done,
  output logic       ok,
  output logic       timeout
);
  import cdp_pkg::*;

  poll_state_t state_q;
  logic        busy_q, lane_q, accept;
  logic        hit, sbit, locked_now, spent_now;

  assign busy_q = (state_q == PS_POLL);
  assign accept = !busy_q && start;

  poll_interval_timer #(.POLL_CYCLES(POLL_CYCLES)) tmr_i (
    .clk(clk), .rst(rst), .run(busy_q), .hit(hit)
  );

  lane_bit_select sel_i (.odd(lane_q), .pair(ready_pair), .bit_o(sbit));

  lock_run_counter #(.NEED_GOOD(NEED_GOOD), .MAX_POLLS(MAX_POLLS)) run_i (
    .clk(clk), .rst(rst), .clear(accept), .sample_en(hit), .sample_bit(sbit),
    .locked_now(locked_now), .spent_now(spent_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      lane_q  <= 1'b0;
      done    <= 1'b0;
      ok      <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q <= PS_POLL;
        lane_q  <= lane_odd;
        ok      <= 1'b0;
        timeout <= 1'b0;
      end else if (busy_q && locked_now) begin
        state_q <= PS_IDLE;
        done    <= 1'b1;
        ok      <= 1'b1;
      end else if (busy_q && spent_now) begin
        state_q <= PS_IDLE;
        done    <= 1'b1;
        timeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_ready_poller_chk.sv
module clk_ready_poller_chk #(
  parameter int POLL_CYCLES = 500000,
  parameter int MAX_POLLS   = 20
) (
  input logic clk,
  input logic rst,
  input logic done,
  input logic ok,
  input logic timeout,
  input logic busy,
  input logic lane
);
  localparam longint LIMIT = longint'(POLL_CYCLES) * MAX_POLLS;
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_outcome_chk: assert property (@(posedge clk) disable iff (rst) done |-> (ok ^ timeout));
  // R7
  ok_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(ok) |-> done);
  // R7
  to_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(timeout) |-> done);
  // R8
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(lane));
  // R6
  budget_chk: assert property (@(posedge clk) disable iff (rst) busy_cnt <= CW'(LIMIT));
endmodule

bind clk_ready_poller clk_ready_poller_chk #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) chk_i (
  .clk(clk), .rst(rst), .done(done), .ok(ok), .timeout(timeout), .busy(busy_q), .lane(lane_q)
);

// File: tb/clk_ready_poller_tb_top.sv
`timescale 1ns/1ps
module clk_ready_poller_tb_top;
  localparam int P = 4;
  localparam int MAXP = 20;
  localparam int NEED = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, lane_odd = 1'b0;
  logic [1:0] ready_pair = 2'b00;
  logic done, ok, timeout;

  int total = 0, bad = 0, cycles = 0;
  logic [19:0] pat = '0;
  logic cur_lane = 1'b0;

  // reference model state
  int m_busy = 0, m_tick = 0, m_polls = 0, m_run = 0, m_lane = 0;
  int m_done = 0, m_ok = 0, m_to = 0;

  always #10 clk = ~clk;

  clk_ready_poller #(.POLL_CYCLES(P), .NEED_GOOD(NEED), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst(rst), .start(start), .lane_odd(lane_odd),
    .ready_pair(ready_pair), .done(done), .ok(ok), .timeout(timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int b;
    if (rst) begin
      m_busy = 0; m_tick = 0; m_polls = 0; m_run = 0;
      m_done = 0; m_ok = 0; m_to = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          m_busy = 1; m_lane = int'(lane_odd); m_tick = 0; m_polls = 0;
          m_run = 0; m_ok = 0; m_to = 0;
        end
      end else begin
        m_tick++;
        if (m_tick == P) begin
          m_tick = 0;
          b = int'(ready_pair[m_lane]);
          m_polls++;
          m_run = b ? m_run + 1 : 0;
          if (m_run >= NEED) begin m_done = 1; m_ok = 1; m_busy = 0; end
          else if (m_polls == MAXP) begin m_done = 1; m_to = 1; m_busy = 0; end
        end
      end
    end
  end

  // pattern driver: selected lane gets pattern, neighbour gets its inverse
  always @(negedge clk) begin
    logic v;
    v = (m_busy != 0 && m_polls < MAXP) ? pat[m_polls] : 1'b0;
    ready_pair[cur_lane]  <= v;
    ready_pair[~cur_lane] <= ~v;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 done", int'(done), m_done);
      chk("R5 ok", int'(ok), m_ok);
      chk("R6 timeout", int'(timeout), m_to);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_case(input string req, input logic lane, input logic [19:0] p,
                          input int exp_polls, input logic exp_ok, input logic interfere);
    int n;
    pat = p; cur_lane = lane;
    @(negedge clk); start = 1'b1; lane_odd = lane;
    @(negedge clk); start = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (start) start = 1'b0;
      if (interfere && n == P + 1) begin start = 1'b1; lane_odd = ~lane; end
    end while (!done && n < P * MAXP + 10);
    start = 1'b0;
    chk({req, " R4 result edge"}, n, exp_polls * P);
    chk({req, " ok"}, int'(ok), int'(exp_ok));
    chk({req, " timeout"}, int'(timeout), int'(!exp_ok));
    repeat (3) @(negedge clk);
    chk({req, " R7 done low after pulse"}, int'(done), 0);
    chk({req, " R7 ok held"}, int'(ok), int'(exp_ok));
    chk({req, " R7 timeout held"}, int'(timeout), int'(!exp_ok));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 ok", int'(ok), 0);
    chk("R1 timeout", int'(timeout), 0);
    rst = 1'b0;
    @(negedge clk);
    run_case("R3 R5 even all good", 1'b0, 20'hFFFFF, 3, 1'b1, 1'b0);
    run_case("R3 R5 odd all good", 1'b1, 20'hFFFFF, 3, 1'b1, 1'b0);
    run_case("R5 broken run", 1'b0, 20'h0003B, 6, 1'b1, 1'b0);
    run_case("R6 never ready", 1'b1, 20'h00000, 20, 1'b0, 1'b0);
    run_case("R6 success on last poll", 1'b0, 20'hE0000, 20, 1'b1, 1'b0);
    run_case("R6 two short", 1'b0, 20'hC0000, 20, 1'b0, 1'b0);
    run_case("R5 alternating", 1'b1, 20'h55555, 20, 1'b0, 1'b0);
    run_case("R2 R8 start while busy", 1'b0, 20'h000E0, 8, 1'b1, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule